// File: doc/BRIEF.md
# Indirect Indexed Address Resolver

The resolver turns an instruction's address part into either an effective memory address or an immediate operand. An instruction word carries an indirect flag, a 2-bit index selector, a literal flag and an 18-bit address field. The resolver holds three 18-bit index registers. When the indirect flag is set, it follows a chain of address words through a read port, fetching one word per level. Every fetched word is decoded with the same layout, and its own index selector is applied at that level.

A request is made by pulsing `start_i` with the word on `instr_i` while the block is idle. A direct word finishes one cycle later. An indirect word holds a read request until the memory answers, and so on down the chain. It ends either in a one-cycle `done_o` pulse with `result_o` and `lit_o`, or, if the chain is longer than the level limit, in a one-cycle `fault_o` pulse.

Top module: `addr_resolver`

## Requirements
- R1: After reset `done_o`, `fault_o`, `busy_o` and `mem_req_o` are low and all three index registers read as zero.
- R2: A write with `idx_we_i` high and `idx_sel_i` equal to 1, 2 or 3 loads `idx_data_i` into that index register. A write with `idx_sel_i` equal to 0 changes no register.
- R3: Word layout: bit 21 is the indirect flag, bits 20:19 the index selector (0 means none), bit 18 the literal flag, bits 17:0 the address. For an accepted word with the indirect flag clear, `done_o` pulses in the next cycle with `result_o` equal to the address plus the selected index register, and no read is issued.
- R4: Every address sum wraps modulo 2^18.
- R5: For an accepted word with the indirect flag set, `mem_req_o` rises in the next cycle with `mem_addr_o` equal to the address plus the selected index. The request and its address stay stable until `mem_rvalid_i` is seen.
- R6: When a fetched word has its indirect flag set, the next read goes to that word's address plus the index register named by that word's own selector.
- R7: The first fetched word with its indirect flag clear ends the chain. `done_o` pulses in the cycle after its arrival, with `result_o` equal to its address plus the index it names, and no further read is issued.
- R8: `lit_o` at `done_o` equals the literal flag of the accepted instruction word. The literal flags of fetched words are ignored.
- R9: At most 16 reads are made per request. If the 16th fetched word still has its indirect flag set, `fault_o` pulses in place of `done_o` and no 17th read is issued.
- R10: `start_i` is ignored while `busy_o` is high.
- R11: `done_o` and `fault_o` are single-cycle pulses, never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| idx_we_i | input | 1 | Index register write enable |
| idx_sel_i | input | 2 | Index register to write (1..3) |
| idx_data_i | input | 18 | Index register write data |
| start_i | input | 1 | Accept `instr_i` when idle |
| instr_i | input | 22 | Instruction address word |
| busy_o | output | 1 | Chain walk in progress |
| mem_req_o | output | 1 | Read request for an address word |
| mem_addr_o | output | 18 | Read address |
| mem_rvalid_i | input | 1 | Read data valid; completes the request |
| mem_rdata_i | input | 22 | Fetched address word |
| done_o | output | 1 | Resolution complete pulse |
| fault_o | output | 1 | Chain limit exceeded pulse |
| lit_o | output | 1 | Result is an operand (1) or an address (0) |
| result_o | output | 18 | Effective address or operand |

## Verification
The assertions assume that the memory raises `mem_rvalid_i` only while `mem_req_o` is high. They also assume that `start_i` pulses count only while the block is idle, and that index registers are not rewritten during a walk. The bench's memory model derives `mem_rvalid_i` from `mem_req_o` combinationally, optionally gated by an alternating stall. Index writes are made only between requests. A second start is driven mid-walk only to show that it is dropped.

// File: rtl/ar_pkg.sv
package ar_pkg;
  localparam int AW      = 18;
  localparam int NUM_IDX = 3;
  localparam int XW      = $clog2(NUM_IDX + 1);
  localparam int WORD_W  = AW + XW + 2;
  localparam int IND_B   = WORD_W - 1;
  localparam int LIT_B   = AW;

  typedef struct packed {
    logic          ind;
    logic [XW-1:0] xs;
    logic          lit;
    logic [AW-1:0] addr;
  } ar_word_t;

  typedef enum logic {ST_IDLE, ST_FETCH} ar_state_t;
endpackage

// File: rtl/ar_idx_regs.sv
module ar_idx_regs
  import ar_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [XW-1:0] wsel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [XW-1:0] rsel_i,
  output logic [AW-1:0] rdata_o
);
  logic [NUM_IDX:1][AW-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
    end else if (we_i) begin
      for (int k = 1; k <= NUM_IDX; k++)
        if (wsel_i == XW'(k)) bank_q[k] <= wdata_i;
    end
  end

  // selector 0 reads as zero offset
  always_comb begin
    rdata_o = '0;
    for (int k = 1; k <= NUM_IDX; k++)
      if (rsel_i == XW'(k)) rdata_o = bank_q[k];
  end
endmodule

// File: rtl/ar_ea_calc.sv
module ar_ea_calc
  import ar_pkg::*;
(
  input  logic          src_mem_i,
  input  logic [AW-1:0] instr_addr_i,
  input  logic [XW-1:0] instr_xs_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [XW-1:0] rd_xs_i,
  input  logic [AW-1:0] idx_val_i,
  output logic [XW-1:0] idx_sel_o,
  output logic [AW-1:0] ea_o
);
  logic [AW-1:0] base;

  assign base      = src_mem_i ? rd_addr_i : instr_addr_i;
  assign idx_sel_o = src_mem_i ? rd_xs_i : instr_xs_i;
  assign ea_o      = base + idx_val_i;  // wraps mod 2^AW
endmodule

// File: rtl/ar_walk_ctrl.sv
module ar_walk_ctrl
  import ar_pkg::*;
#(
  parameter int MAX_LVL = 16,
  localparam int LVL_W  = $clog2(MAX_LVL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          instr_ind_i,
  input  logic          instr_lit_i,
  input  logic          rd_ind_i,
  input  logic          rvalid_i,
  input  logic [AW-1:0] ea_i,
  output logic          src_mem_o,
  output logic          busy_o,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          done_o,
  output logic          fault_o,
  output logic          lit_o,
  output logic [AW-1:0] res_o
);
  ar_state_t        state_q;
  logic [LVL_W-1:0] lvl_q;

  assign src_mem_o = (state_q == ST_FETCH);
  assign busy_o    = (state_q == ST_FETCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      req_o   <= 1'b0;
      addr_o  <= '0;
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      lit_o   <= 1'b0;
      res_o   <= '0;
    end else begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          lit_o <= instr_lit_i;
          if (instr_ind_i) begin
            state_q <= ST_FETCH;
            req_o   <= 1'b1;
            addr_o  <= ea_i;
            lvl_q   <= LVL_W'(1);
          end else begin
            res_o  <= ea_i;
            done_o <= 1'b1;
          end
        end
        ST_FETCH: if (rvalid_i) begin
          if (rd_ind_i) begin
            if (lvl_q == LVL_W'(MAX_LVL)) begin
              fault_o <= 1'b1;
              req_o   <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              addr_o <= ea_i;
              lvl_q  <= lvl_q + 1'b1;
            end
          end else begin
            res_o   <= ea_i;
            done_o  <= 1'b1;
            req_o   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addr_resolver.sv
module addr_resolver
  import ar_pkg::*;
#(
  parameter int MAX_LVL = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic [XW-1:0]     idx_sel_i,
  input  logic [AW-1:0]     idx_data_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] instr_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic              lit_o,
  output logic [AW-1:0]     result_o
);
  ar_word_t      iw, rw;
  logic          src_mem;
  logic [XW-1:0] rsel;
  logic [AW-1:0] idx_val, ea;

  assign iw = ar_word_t'(instr_i);
  assign rw = ar_word_t'(mem_rdata_i);

  ar_idx_regs i_idx (
    .clk_i, .rst_ni,
    .we_i(idx_we_i), .wsel_i(idx_sel_i), .wdata_i(idx_data_i),
    .rsel_i(rsel), .rdata_o(idx_val)
  );

  ar_ea_calc i_calc (
    .src_mem_i(src_mem),
    .instr_addr_i(iw.addr), .instr_xs_i(iw.xs),
    .rd_addr_i(rw.addr), .rd_xs_i(rw.xs),
    .idx_val_i(idx_val), .idx_sel_o(rsel), .ea_o(ea)
  );

  ar_walk_ctrl #(.MAX_LVL(MAX_LVL)) i_ctrl (
    .clk_i, .rst_ni,
    .start_i, .instr_ind_i(iw.ind), .instr_lit_i(iw.lit),
    .rd_ind_i(rw.ind), .rvalid_i(mem_rvalid_i), .ea_i(ea),
    .src_mem_o(src_mem), .busy_o,
    .req_o(mem_req_o), .addr_o(mem_addr_o),
    .done_o, .fault_o, .lit_o, .res_o(result_o)
  );
endmodule

// File: rtl/ar_checker.sv
module ar_checker
  import ar_pkg::*;
#(
  parameter int MAX_LVL = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          instr_ind_i,
  input logic          instr_lit_i,
  input logic          busy_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rvalid_i,
  input logic          done_o,
  input logic          fault_o,
  input logic          lit_o
);
  localparam int CW = $clog2(MAX_LVL + 2) + 1;
  logic [CW-1:0] reads_q;
  logic          lit_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reads_q    <= '0;
      lit_seen_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      reads_q    <= '0;
      lit_seen_q <= instr_lit_i;
    end else if (mem_req_o && mem_rvalid_i) begin
      reads_q <= reads_q + 1'b1;
    end
  end

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  assert_req_only_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  assert_direct_no_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !instr_ind_i |=> done_o && !mem_req_o);

  assert_read_limit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reads_q <= CW'(MAX_LVL));

  assert_lit_origin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lit_o == lit_seen_q);

  assert_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  assert_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o || fault_o |=> !done_o && !fault_o);
endmodule

bind addr_resolver ar_checker #(.MAX_LVL(MAX_LVL)) i_ar_checker (
  .clk_i, .rst_ni, .start_i,
  .instr_ind_i(instr_i[ar_pkg::IND_B]),
  .instr_lit_i(instr_i[ar_pkg::LIT_B]),
  .busy_o, .mem_req_o, .mem_addr_o, .mem_rvalid_i,
  .done_o, .fault_o, .lit_o
);

// File: tb/test_addr_resolver.sv
module test_addr_resolver;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        idx_we = 1'b0;
  logic [1:0]  idx_sel = '0;
  logic [17:0] idx_data = '0;
  logic        start = 1'b0;
  logic [21:0] instr = '0;
  logic        busy, mem_req, mem_rvalid, done, fault, lit;
  logic [17:0] mem_addr, result;
  logic [21:0] mem_rdata;
  logic [21:0] mem [256];
  logic        stall_en = 1'b0, phase = 1'b0;
  int          n_chk = 0, n_bad = 0;
  int          n_reads;
  logic [17:0] seen [32];
  bit          got_done, got_fault;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) phase <= ~phase;

  assign mem_rdata  = mem[mem_addr[7:0]];
  assign mem_rvalid = mem_req & (~stall_en | phase);

  addr_resolver i_addr_resolver (
    .clk_i(clk), .rst_ni(rst_n),
    .idx_we_i(idx_we), .idx_sel_i(idx_sel), .idx_data_i(idx_data),
    .start_i(start), .instr_i(instr),
    .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .lit_o(lit), .result_o(result)
  );

  function automatic logic [21:0] w(bit ind, logic [1:0] x, bit l, logic [17:0] a);
    return {ind, x, l, a};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_idx(logic [1:0] s, logic [17:0] d);
    @(negedge clk);
    idx_we = 1'b1; idx_sel = s; idx_data = d;
    @(negedge clk);
    idx_we = 1'b0;
  endtask

  // launch one word, collect read addresses until done/fault
  task automatic resolve(logic [21:0] word);
    @(negedge clk);
    start = 1'b1; instr = word;
    @(negedge clk);
    start = 1'b0;
    n_reads = 0; got_done = 0; got_fault = 0;
    for (int c = 0; c < 400; c++) begin
      if (mem_req && mem_rvalid) begin
        if (n_reads < 32) seen[n_reads] = mem_addr;
        n_reads++;
      end
      if (done || fault) begin
        got_done = done; got_fault = fault;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    chk("R11 single pulse", {30'd0, done, fault}, 0);
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 fault", fault, 0);
    chk("R1 busy", busy, 0);
    chk("R1 req", mem_req, 0);
    resolve(w(0, 3, 0, 18'h00123));
    chk("R1 idx3 zero", result, 18'h00123);
  endtask

  task automatic t_idx_write();
    set_idx(1, 18'h00005);
    set_idx(2, 18'h00040);
    set_idx(3, 18'h3FFFF);
    set_idx(0, 18'h11111);  // must not land anywhere
    resolve(w(0, 1, 0, 18'h00100));
    chk("R2 idx1", result, 18'h00105);
    resolve(w(0, 2, 0, 18'h00100));
    chk("R2 idx2", result, 18'h00140);
    resolve(w(0, 3, 0, 18'h00100));
    chk("R2 idx3 after sel0 write", result, 18'h000FF);
  endtask

  task automatic t_direct();
    @(negedge clk);
    start = 1'b1; instr = w(0, 1, 1, 18'h00200);
    @(negedge clk);
    start = 1'b0;
    chk("R3 done next cycle", done, 1);
    chk("R3 no read", mem_req, 0);
    chk("R3 result", result, 18'h00205);
    chk("R3 lit", lit, 1);
    @(negedge clk);
    chk("R11 done drops", done, 0);
  endtask

  task automatic t_wrap();
    resolve(w(0, 3, 0, 18'h00000));
    chk("R4 wrap below zero", result, 18'h3FFFF);
    set_idx(2, 18'h00020);
    resolve(w(0, 2, 1, 18'h3FFF0));
    chk("R4 wrap above top", result, 18'h00010);
    set_idx(2, 18'h00040);
  endtask

  task automatic t_chain(bit stall, bit l);
    stall_en = stall;
    mem[8'h25] = w(1, 2, ~l, 18'h00030);  // lit flag here must be ignored
    mem[8'h70] = w(0, 3, ~l, 18'h00090);
    @(negedge clk);
    start = 1'b1; instr = w(1, 1, l, 18'h00020);
    @(negedge clk);
    start = 1'b0;
    chk("R5 req after start", mem_req, 1);
    chk("R5 first addr", mem_addr, 18'h00025);
    for (int c = 0; c < 40 && !(done || fault); c++) begin
      if (mem_req && !mem_rvalid) begin
        logic [17:0] a = mem_addr;
        @(negedge clk);
        chk("R5 held", {13'd0, mem_req, a}, {13'd0, 1'b1, mem_addr});
      end else @(negedge clk);
    end
    stall_en = 0;
    resolve(w(1, 1, l, 18'h00020));
    chk("R7 done", got_done, 1);
    chk("R6 two reads", n_reads, 2);
    chk("R6 second addr uses word idx", seen[1], 18'h00070);
    chk("R7 final plus idx3", result, 18'h0008F);
    chk("R8 lit from instr", lit, l);
  endtask

  task automatic t_limit(bit over);
    for (int k = 0; k < 16; k++)
      mem[8'h80 + k] = w(1, 0, 0, 18'h00081 + k);
    mem[8'h8F] = w(over, 0, 0, over ? 18'h00090 : 18'h00055);
    resolve(w(1, 0, 0, 18'h00080));
    chk(over ? "R9 reads capped" : "R9 16 reads allowed", n_reads, 16);
    chk(over ? "R9 fault" : "R9 done at limit", {30'd0, got_done, got_fault},
        over ? 1 : 2);
    if (!over) chk("R9 result", result, 18'h00055);
  endtask

  task automatic t_busy_ignore();
    mem[8'h25] = w(0, 0, 0, 18'h00077);
    stall_en = 1'b1;
    @(negedge clk);
    start = 1'b1; instr = w(1, 1, 0, 18'h00020);
    @(negedge clk);
    instr = w(0, 0, 1, 18'h00333);  // start still high while busy
    chk("R10 busy", busy, 1);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 20 && !done; c++) @(negedge clk);
    chk("R10 chain result kept", result, 18'h00077);
    chk("R10 lit kept", lit, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R10 no second done", done, 0);
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idx_write();
    t_direct();
    t_wrap();
    t_chain(0, 0);
    t_chain(1, 1);
    t_limit(0);
    t_limit(1);
    resolve(w(0, 0, 0, 18'h00042));
    chk("R9 recovers after fault", result, 18'h00042);
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule